// File: doc/BRIEF.md
# Framebuffer Line Fetch Request Generator

This block walks a display framebuffer one line at a time and turns each line into a series of burst read requests for a memory fabric. A one-cycle frame-start pulse, given while the block is idle, captures the scan configuration. The configuration is the start address, the bytes to fetch per line, the address step between lines, the line count minus one, the preferred burst size and the cap on outstanding reads. The block then issues requests until every line has been covered. Read responses come back beat by beat. The block counts completed requests so that it never has more in flight than the cap. It raises a one-cycle end-of-frame pulse once the last response of the final line has arrived.

Requests leave through a valid/ready channel. Once `req_valid` is high it stays high, and `req_addr` and `req_beats` stay fixed, until a cycle in which `req_ready` is also high. That cycle transfers the request. The response side cannot be stalled. Every cycle with `rsp_valid` high is one returned beat, and `rsp_last` marks the final beat of a request. Software pans the picture by whole lines by writing a new start address during a frame. That address is used from the next frame-start pulse onward.

Top module: `fb_scan_addrgen`

## Requirements
- R1: A `frame_start` pulse while `busy` is low latches the configuration and starts a scan, with `busy` high from the next cycle. A pulse while `busy` is high is ignored: it neither restarts the scan nor adds an end-of-frame pulse. `req_valid` is never high while `busy` is low.
- R2: A scan covers `cfg_line_cnt + 1` lines. Line L starts at address `base + L * cfg_pitch`. Requests within a line are issued in ascending address order. Each request's address is the line start plus 8 bytes (BEAT_BYTES) for every beat already requested on that line.
- R3: The `cfg_burst_sel` bits 0, 1, 2, 3 and 4 select bursts of 1, 2, 4, 8 and 16 beats. If several bits are set, the highest one wins. All zero means single-beat requests.
- R4: Each line is fetched as ceil(`cfg_line_len` / 8) beats, and a line length of zero fetches one beat. Any request that would pass the end of the line is shortened to the beats that remain, so `req_beats` always lies between 1 and 16.
- R5: The cap on outstanding reads is `cfg_max_out`, with 0 treated as 1. A request is outstanding from its transfer until its response beat with `rsp_last` high. No request is offered while the outstanding count equals the cap.
- R6: While `req_valid` is high and `req_ready` is low, the next cycle keeps `req_valid` high with unchanged `req_addr` and `req_beats`.
- R7: A change of `cfg_base` during a scan has no effect on that scan's addresses. Only the next frame-start pulse picks it up.
- R8: `irq_dma_end` pulses high for exactly one cycle per scan, and only after every request of the scan has been transferred and fully answered. `busy` is low in that same cycle.
- R9: A response beat with `rsp_err` high gives a one-cycle `irq_bus_err` pulse in the following cycle. Scanning continues with the remaining requests.
- R10: During and right after reset, `req_valid`, `busy`, `irq_dma_end` and `irq_bus_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a scan when idle |
| cfg_base | input | ADDR_W | Start address of the first line |
| cfg_line_len | input | LEN_W | Bytes fetched per line |
| cfg_pitch | input | LEN_W | Address step between line starts |
| cfg_line_cnt | input | LINE_W | Number of lines minus one |
| cfg_burst_sel | input | 5 | One-hot preferred burst size |
| cfg_max_out | input | 4 | Outstanding request cap, 0 means 1 |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Fabric accepts the request this cycle |
| req_addr | output | ADDR_W | Byte address of the request |
| req_beats | output | 5 | Beats in the request, 1 to 16 |
| rsp_valid | input | 1 | One response beat this cycle |
| rsp_last | input | 1 | Final beat of a request |
| rsp_err | input | 1 | Error flag on this beat |
| busy | output | 1 | Scan in progress |
| irq_dma_end | output | 1 | End-of-frame pulse |
| irq_bus_err | output | 1 | Bus error pulse |

## Verification
The bound checker watches several rules on every cycle. It checks that a stalled request is held, and it keeps its own in-flight count from the ports to confirm the cap. It also checks that burst lengths stay in range, that an error beat is followed by the error pulse, and that the end pulse comes only when idle with nothing in flight. Other behaviour can only be shown by the bench's scenarios, which compare each request against a sequence computed arithmetically. These include the exact address and length order across lines, the shortening of a line's final burst, the burst-select priority and the rounding up of line length. They also include the deferred use of a panned base address and the rejection of a second frame start. The bench sweeps burst sizes, line lengths, line counts and caps under random back-pressure and random response timing.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  localparam int BURST_W = 5;
  localparam int CAP_W   = 4;

  typedef enum logic [1:0] {
    SCAN_IDLE  = 2'd0,
    SCAN_RUN   = 2'd1,
    SCAN_DRAIN = 2'd2
  } scan_state_e;

  function automatic logic [CAP_W:0] eff_cap(input logic [CAP_W-1:0] field);
    return (field == '0) ? (CAP_W+1)'(1) : {1'b0, field};
  endfunction
endpackage

// File: rtl/fbscan_burst_dec.sv
module fbscan_burst_dec
  import fbscan_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [BURST_W-1:0] sel,
  input  logic [LEN_W-1:0]   remain,
  output logic [BURST_W-1:0] beats
);
  logic [BURST_W-1:0] nominal;

  // highest selected bit wins; nothing selected means single beats
  always_comb begin
    nominal = BURST_W'(1);
    for (int i = 0; i < BURST_W; i++) begin
      if (sel[i]) nominal = BURST_W'(1 << i);
    end
  end

  assign beats = (remain < LEN_W'(nominal)) ? remain[BURST_W-1:0] : nominal;
endmodule

// File: rtl/fbscan_credit.sv
module fbscan_credit
  import fbscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAP_W-1:0] cap_field,
  input  logic             take,
  input  logic             give,
  output logic             can_issue,
  output logic             empty
);
  logic [CAP_W:0] count;
  logic [CAP_W:0] cap;

  assign cap = eff_cap(cap_field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (take && !give) count <= count + 1'b1;
    else if (give && !take) count <= count - 1'b1;
  end

  assign can_issue = count < cap;
  assign empty     = count == '0;
endmodule

// File: rtl/fb_scan_addrgen.sv
module fb_scan_addrgen
  import fbscan_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_W     = 12,
  parameter int BEAT_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [LEN_W-1:0]    cfg_line_len,
  input  logic [LEN_W-1:0]    cfg_pitch,
  input  logic [LINE_W-1:0]   cfg_line_cnt,
  input  logic [BURST_W-1:0]  cfg_burst_sel,
  input  logic [CAP_W-1:0]    cfg_max_out,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [BURST_W-1:0]  req_beats,
  input  logic                rsp_valid,
  input  logic                rsp_last,
  input  logic                rsp_err,
  output logic                busy,
  output logic                irq_dma_end,
  output logic                irq_bus_err
);
  localparam int BEAT_SH = $clog2(BEAT_BYTES);

  scan_state_e        state;
  logic [ADDR_W-1:0]  line_addr;
  logic [LEN_W-1:0]   pitch_q;
  logic [LEN_W-1:0]   line_beats_q;
  logic [LEN_W-1:0]   rem_q;
  logic [LEN_W-1:0]   off_q;
  logic [LINE_W-1:0]  line_idx;
  logic [LINE_W-1:0]  last_line;
  logic [BURST_W-1:0] sel_q;
  logic [CAP_W-1:0]   cap_q;
  logic               dma_end_q;
  logic               bus_err_q;

  logic [LEN_W:0]     len_round;
  logic [LEN_W-1:0]   start_beats;
  logic               can_issue;
  logic               drained;
  logic               fire;
  logic               line_done;

  // bytes to beats, rounding a partial beat up, never fewer than one beat
  assign len_round   = ({1'b0, cfg_line_len} + (LEN_W+1)'(BEAT_BYTES - 1)) >> BEAT_SH;
  assign start_beats = (len_round == '0) ? LEN_W'(1) : len_round[LEN_W-1:0];

  fbscan_burst_dec #(.LEN_W(LEN_W)) u_dec (
    .sel    (sel_q),
    .remain (rem_q),
    .beats  (req_beats)
  );

  fbscan_credit u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_field (cap_q),
    .take      (fire),
    .give      (rsp_valid && rsp_last),
    .can_issue (can_issue),
    .empty     (drained)
  );

  assign req_valid = (state == SCAN_RUN) && can_issue;
  assign req_addr  = line_addr + (ADDR_W'(off_q) << BEAT_SH);
  assign fire      = req_valid && req_ready;
  assign line_done = rem_q == LEN_W'(req_beats);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SCAN_IDLE;
      line_addr    <= '0;
      pitch_q      <= '0;
      line_beats_q <= '0;
      rem_q        <= '0;
      off_q        <= '0;
      line_idx     <= '0;
      last_line    <= '0;
      sel_q        <= '0;
      cap_q        <= '0;
      dma_end_q    <= 1'b0;
    end else begin
      dma_end_q <= 1'b0;
      unique case (state)
        SCAN_IDLE: begin
          if (frame_start) begin
            line_addr    <= cfg_base;
            pitch_q      <= cfg_pitch;
            line_beats_q <= start_beats;
            rem_q        <= start_beats;
            off_q        <= '0;
            line_idx     <= '0;
            last_line    <= cfg_line_cnt;
            sel_q        <= cfg_burst_sel;
            cap_q        <= cfg_max_out;
            state        <= SCAN_RUN;
          end
        end
        SCAN_RUN: begin
          if (fire) begin
            if (line_done) begin
              if (line_idx == last_line) begin
                state <= SCAN_DRAIN;
              end else begin
                line_addr <= line_addr + ADDR_W'(pitch_q);
                line_idx  <= line_idx + 1'b1;
                off_q     <= '0;
                rem_q     <= line_beats_q;
              end
            end else begin
              off_q <= off_q + LEN_W'(req_beats);
              rem_q <= rem_q - LEN_W'(req_beats);
            end
          end
        end
        SCAN_DRAIN: begin
          if (drained) begin
            state     <= SCAN_IDLE;
            dma_end_q <= 1'b1;
          end
        end
        default: state <= SCAN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_err_q <= 1'b0;
    else        bus_err_q <= rsp_valid && rsp_err;
  end

  assign busy        = state != SCAN_IDLE;
  assign irq_dma_end = dma_end_q;
  assign irq_bus_err = bus_err_q;
endmodule

// File: rtl/fbscan_checker.sv
module fbscan_checker
  import fbscan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               busy,
  input logic [CAP_W-1:0]   cfg_max_out,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [BURST_W-1:0] req_beats,
  input logic               rsp_valid,
  input logic               rsp_last,
  input logic               rsp_err,
  input logic               irq_dma_end,
  input logic               irq_bus_err
);
  logic [CAP_W:0] own_out;
  logic [CAP_W:0] cap_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_out <= '0;
      cap_l   <= (CAP_W+1)'(1);
    end else begin
      own_out <= own_out + (CAP_W+1)'(req_valid && req_ready)
                         - (CAP_W+1)'(rsp_valid && rsp_last);
      if (frame_start && !busy) cap_l <= eff_cap(cfg_max_out);
    end
  end

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_beats));

  assert_out_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> own_out < cap_l);

  assert_beats_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0) && (req_beats <= BURST_W'(16)));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |=> irq_bus_err);

  assert_end_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dma_end |-> !busy && own_out == '0);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
endmodule

bind fb_scan_addrgen fbscan_checker #(.ADDR_W(ADDR_W)) u_fbscan_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .busy        (busy),
  .cfg_max_out (cfg_max_out),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_beats   (req_beats),
  .rsp_valid   (rsp_valid),
  .rsp_last    (rsp_last),
  .rsp_err     (rsp_err),
  .irq_dma_end (irq_dma_end),
  .irq_bus_err (irq_bus_err)
);

// File: tb/test_fb_scan_addrgen.sv
`timescale 1ns/1ps
module test_fb_scan_addrgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_line_len = '0;
  logic [15:0] cfg_pitch = '0;
  logic [11:0] cfg_line_cnt = '0;
  logic [4:0]  cfg_burst_sel = '0;
  logic [3:0]  cfg_max_out = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [4:0]  req_beats;
  logic        rsp_valid = 1'b0;
  logic        rsp_last = 1'b0;
  logic        rsp_err = 1'b0;
  logic        busy;
  logic        irq_dma_end;
  logic        irq_bus_err;

  always #4 clk = ~clk;

  fb_scan_addrgen i_fb_scan_addrgen (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_base(cfg_base), .cfg_line_len(cfg_line_len), .cfg_pitch(cfg_pitch),
    .cfg_line_cnt(cfg_line_cnt), .cfg_burst_sel(cfg_burst_sel), .cfg_max_out(cfg_max_out),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_err(rsp_err),
    .busy(busy), .irq_dma_end(irq_dma_end), .irq_bus_err(irq_bus_err)
  );

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_addr [0:1023];
  int          exp_beats [0:1023];
  int          exp_n = 0;
  int          got_n = 0;
  logic [4:0]  pend [0:255];
  int ph = 0, pt = 0, head_left = 0;
  int bench_out = 0, max_out = 0;
  int beat_no = 0, err_at = -1;
  int err_pulses = 0, err_misalign = 0, dma_pulses = 0, dma_early = 0, hold_viol = 0;
  logic        err_prev = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        stalled = 1'b0;
  logic [31:0] st_addr = '0;
  logic [4:0]  st_beats = '0;
  logic        done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // memory fabric model: random accept, random response timing
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rsp_valid = 1'b0; rsp_last = 1'b0; rsp_err = 1'b0; req_ready = 1'b0;
      end else begin
        if (irq_bus_err) err_pulses++;
        if (irq_bus_err !== err_prev) err_misalign++;
        if (irq_dma_end) begin
          dma_pulses++;
          if (ph != pt || got_n != exp_n) dma_early++;
        end
        if (stalled && !(req_valid && req_addr == st_addr && req_beats == st_beats)) hold_viol++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rsp_valid = 1'b0; rsp_last = 1'b0; rsp_err = 1'b0;
        if (ph != pt && lfsr[0]) begin
          rsp_valid = 1'b1;
          if (beat_no == err_at) rsp_err = 1'b1;
          beat_no++;
          head_left--;
          if (head_left == 0) begin
            rsp_last = 1'b1;
            bench_out--;
            ph = (ph + 1) % 256;
            if (ph != pt) head_left = pend[ph];
          end
        end
        err_prev = rsp_err;
        req_ready = lfsr[1] | lfsr[2];
        stalled = req_valid && !req_ready;
        st_addr = req_addr; st_beats = req_beats;
        if (req_valid && req_ready) begin
          if (got_n < exp_n) begin
            chk(req_addr == exp_addr[got_n], "R2 request address", req_addr, exp_addr[got_n]);
            chk(int'(req_beats) == exp_beats[got_n], "R3/R4 request beats", req_beats, exp_beats[got_n]);
          end else begin
            chk(1'b0, "R2 request beyond expected count", got_n + 1, exp_n);
          end
          pend[pt] = req_beats;
          if (ph == pt) head_left = req_beats;
          pt = (pt + 1) % 256;
          got_n++;
          bench_out++;
          if (bench_out > max_out) max_out = bench_out;
        end
      end
    end
  end

  task automatic run_frame(input logic [31:0] base, input int lbytes, input int pitch,
                           input int cnt, input logic [4:0] sel, input logic [3:0] mo,
                           input int err_idx, input bit pan, input logic [31:0] pan_base,
                           input bit extra_start);
    int nb, lb, off, b, total, capv, t;
    nb = 1;
    for (int i = 0; i < 5; i++) if (sel[i]) nb = 1 << i;
    lb = (lbytes + 7) / 8;
    if (lb == 0) lb = 1;
    capv = (mo == 0) ? 1 : int'(mo);
    exp_n = 0; total = 0;
    for (int l = 0; l <= cnt; l++) begin
      off = 0;
      while (off < lb) begin
        b = (lb - off < nb) ? lb - off : nb;
        exp_addr[exp_n] = base + 32'(l * pitch) + 32'(off * 8);
        exp_beats[exp_n] = b;
        exp_n++; total += b; off += b;
      end
    end
    @(negedge clk);
    got_n = 0; beat_no = 0; err_at = err_idx; err_pulses = 0; err_misalign = 0;
    dma_pulses = 0; dma_early = 0; max_out = 0; hold_viol = 0;
    cfg_base = base; cfg_line_len = 16'(lbytes); cfg_pitch = 16'(pitch);
    cfg_line_cnt = 12'(cnt); cfg_burst_sel = sel; cfg_max_out = mo;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(busy == 1'b1, "R1 busy after frame start", busy, 1);
    if (pan) begin
      repeat (3) @(negedge clk);
      cfg_base = pan_base;
    end
    if (extra_start) begin
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
    t = 0;
    while (dma_pulses == 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    chk(got_n == exp_n, "R2/R4 request count", got_n, exp_n);
    chk(dma_pulses == 1, "R8 end pulse count", dma_pulses, 1);
    chk(dma_early == 0, "R8 end pulse before last response", dma_early, 0);
    chk(max_out <= capv, "R5 outstanding cap", max_out, capv);
    chk(hold_viol == 0, "R6 stalled request held", hold_viol, 0);
    chk(err_pulses == ((err_idx >= 0 && err_idx < total) ? 1 : 0), "R9 bus error pulses",
        err_pulses, (err_idx >= 0 && err_idx < total) ? 1 : 0);
    chk(err_misalign == 0, "R9 bus error timing", err_misalign, 0);
    chk(busy == 1'b0, "R1 idle after frame", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R10 reset req_valid", req_valid, 0);
    chk(busy == 1'b0, "R10 reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0 && irq_dma_end == 1'b0 && irq_bus_err == 1'b0,
        "R10 outputs quiet after reset", {req_valid, irq_dma_end, irq_bus_err}, 0);
    // sweep: R3 burst sizes, R4 shortening and rounding, R2 line counts, R5 caps
    foreach (exp_beats[k]) exp_beats[k] = 0;
    for (int s = 0; s < 6; s++) begin
      for (int li = 0; li < 5; li++) begin
        for (int c = 0; c < 2; c++) begin
          for (int m = 0; m < 2; m++) begin
            automatic int lbt = (li == 0) ? 1 : (li == 1) ? 3 : (li == 2) ? 5 : (li == 3) ? 16 : 17;
            automatic int lby = (li % 2 == 1) ? lbt * 8 - 3 : lbt * 8;
            automatic logic [4:0] sv = (s == 0) ? 5'd0 : 5'(1 << (s - 1));
            run_frame(32'h0010_0000 + 32'(s * 4096), lby, lbt * 8 + 32, c * 2, sv,
                      (m == 0) ? 4'd0 : 4'd2, -1, 1'b0, 32'h0, 1'b0);
          end
        end
      end
    end
    // R3 two bits set: highest wins (4 beats)
    run_frame(32'h0002_0000, 80, 128, 1, 5'b00110, 4'd3, -1, 1'b0, 32'h0, 1'b0);
    // R4 zero line length fetches one beat
    run_frame(32'h0003_0000, 0, 64, 2, 5'b10000, 4'd4, -1, 1'b0, 32'h0, 1'b0);
    // R7 panning: mid-frame base write unused now, used next frame
    run_frame(32'h0000_1000, 128, 256, 3, 5'b00100, 4'd2, -1, 1'b1, 32'h0000_8000, 1'b0);
    run_frame(32'h0000_8000, 128, 256, 3, 5'b00100, 4'd2, -1, 1'b0, 32'h0, 1'b0);
    // R1 second frame start during a scan is ignored
    run_frame(32'h0004_0000, 256, 256, 3, 5'b00010, 4'd1, -1, 1'b0, 32'h0, 1'b1);
    // R9 error beats mid-scan, scan continues
    run_frame(32'h0005_0000, 64, 96, 2, 5'b01000, 4'd3, 5, 1'b0, 32'h0, 1'b0);
    run_frame(32'h0006_0000, 40, 64, 0, 5'b00000, 4'd15, 0, 1'b0, 32'h0, 1'b0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule